// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block decides, for every instruction a serial flash receives, whether that instruction may run. Its input is an already decoded instruction: opcode, 24-bit address, the number of serial clocks counted while chip select was low, and the data byte used by a status write. It holds the write-enable latch, the busy flag and the protection fields of the status register. It combines these with the level of the write-protect pin and returns accept or reject together with the status byte.

Instructions arrive as a single-cycle `cmd_valid` strobe. The block takes one instruction per cycle and never applies back-pressure, so the interface has no ready signal. The result comes out as a `res_valid` strobe. When an instruction that modifies data is accepted, the block raises busy and pulses `eng_start` toward a program/erase engine. That engine later pulses `eng_done`, which ends the operation.

Top module: `flash_wp_ctrl`

## Requirements
- R1: Page Program (0x02), Sector Erase (0xD8), Bulk Erase (0xC7) and Write Status (0x01) are rejected while the write-enable latch (status bit 1) is clear. An accepted Write Enable (0x06) sets the latch.
- R2: The latch is cleared by power-on reset (`por_n` low), by an accepted Write Disable (0x04), and by the `eng_done` pulse that ends a program, erase or status write.
- R3: A data-modifying instruction is accepted only when the three low bits of `cmd_bits` are zero, meaning the clock count is a whole number of bytes.
- R4: The protect field (status bits 4:2) selects a protected top region. The first protected sector is 128 for field 0 (nothing protected), 126 for 1, 124 for 2, 120 for 3, 112 for 4, 96 for 5, 64 for 6 and 0 for 7. The sector is `cmd_addr[22:16]`, and bit 23 is ignored. Page Program or Sector Erase to a protected sector is rejected; sectors below the region stay writable.
- R5: Bulk Erase is accepted only when the protect field is 0.
- R6: An accepted Write Status loads status bit 7 (write-disable) from `cmd_wdata[7]` and the protect field from `cmd_wdata[4:2]`. When bit 7 is set and `wp_n` is low, Write Status is rejected.
- R7: An accepted data-modifying instruction sets busy (status bit 0) and pulses `eng_start` with its opcode on `eng_op`. While busy is set, every instruction except Read Status (0x05) is rejected. `eng_done` clears busy.
- R8: A rejected instruction, including any unlisted opcode, leaves the status register unchanged.
- R9: `res_valid` follows `cmd_valid` by exactly one cycle. `res_status` is the status byte {write-disable, 0, 0, protect[2:0], latch, busy} as it stood before the instruction. After reset all status bits are zero and `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| cmd_valid | input | 1 | One decoded instruction this cycle |
| cmd_op | input | 8 | Opcode |
| cmd_addr | input | 24 | Byte address |
| cmd_bits | input | 16 | Serial clocks counted during chip select |
| cmd_wdata | input | 8 | Data byte for Write Status |
| wp_n | input | 1 | Write-protect pin level, active low |
| eng_done | input | 1 | Completion pulse from program/erase engine |
| eng_start | output | 1 | Start pulse toward the engine |
| eng_op | output | 8 | Opcode handed to the engine |
| res_valid | output | 1 | Result strobe |
| res_accept | output | 1 | Instruction accepted |
| res_status | output | 8 | Status byte before the instruction |

## Verification
Every instruction produces its accept flag, status byte and start pulse one cycle after its strobe. A latch, busy or protect change caused by an instruction therefore first shows in the status reported for the next instruction. An `eng_done` pulse takes effect at the clock edge that samples it. The driver presents each instruction at a falling edge and records its expected result in a queue. The monitor compares at the following falling edge, which is the first one after the registering rising edge. Nothing is sampled at an edge.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_SE   = 8'hD8;
  localparam logic [7:0] OP_BE   = 8'hC7;

  typedef struct packed {
    logic       srwd;
    logic [1:0] rsvd;
    logic [2:0] bp;
    logic       wel;
    logic       wip;
  } stat_t;

  function automatic logic is_modify(input logic [7:0] op);
    return (op == OP_PP) || (op == OP_SE) || (op == OP_BE) || (op == OP_WRSR);
  endfunction
endpackage

// File: rtl/wp_region_decode.sv
module wp_region_decode #(
  parameter int SECT_BITS = 7,
  parameter int BP_W      = 3
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic [BP_W-1:0]      bp,
  input  logic [SECT_BITS-1:0] sector,
  output logic                 hit,
  output logic                 all_clear
);
  localparam int NUM_SECT = 1 << SECT_BITS;
  localparam int MAX_BP   = (1 << BP_W) - 1;

  logic [SECT_BITS:0] size;
  logic [SECT_BITS:0] first;

  // region size doubles per step, top code covers the whole array
  always_comb begin
    if (bp == '0) size = '0;
    else          size = (SECT_BITS+1)'(NUM_SECT) >> (MAX_BP - int'(bp));
    first     = (SECT_BITS+1)'(NUM_SECT) - size;
    hit       = {1'b0, sector} >= first;
    all_clear = (bp == '0);
  end

  // R4
  no_hit_when_open_chk: assert property (@(posedge clk) disable iff (!por_n)
    all_clear |-> !hit);
  // R4
  top_sector_hit_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!all_clear && sector == SECT_BITS'(NUM_SECT-1)) |-> hit);
endmodule

// File: rtl/wp_cmd_check.sv
module wp_cmd_check
  import wp_pkg::*;
(
  input  logic       valid,
  input  logic [7:0] op,
  input  logic [2:0] bits_lo,
  input  stat_t      st,
  input  logic       wp_n,
  input  logic       prot_hit,
  input  logic       bp_clear,
  output logic       accept,
  output logic       set_wel,
  output logic       clr_wel,
  output logic       load_sr,
  output logic       start
);
  logic mod_ok;
  logic hw_lock;

  always_comb begin
    mod_ok  = st.wel && (bits_lo == 3'd0);
    hw_lock = st.srwd && !wp_n;
    accept  = 1'b0;
    set_wel = 1'b0;
    clr_wel = 1'b0;
    load_sr = 1'b0;
    if (valid) begin
      if (st.wip) begin
        accept = (op == OP_RDSR);
      end else begin
        case (op)
          OP_RDSR: accept = 1'b1;
          OP_WREN: begin accept = 1'b1; set_wel = 1'b1; end
          OP_WRDI: begin accept = 1'b1; clr_wel = 1'b1; end
          OP_PP,
          OP_SE:   accept = mod_ok && !prot_hit;
          OP_BE:   accept = mod_ok && bp_clear;
          OP_WRSR: begin accept = mod_ok && !hw_lock; load_sr = accept; end
          default: accept = 1'b0;
        endcase
      end
    end
    start = accept && is_modify(op);
  end
endmodule

// File: rtl/wp_status_regs.sv
module wp_status_regs
  import wp_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       set_wel,
  input  logic       clr_wel,
  input  logic       load_sr,
  input  logic [7:0] sr_wdata,
  input  logic       start,
  input  logic       done,
  output stat_t      st
);
  stat_t q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      q <= '0;
    end else begin
      if (done && q.wip) begin
        q.wip <= 1'b0;
        q.wel <= 1'b0;
      end else begin
        if (start)        q.wip <= 1'b1;
        if (clr_wel)      q.wel <= 1'b0;
        else if (set_wel) q.wel <= 1'b1;
      end
      if (load_sr) begin
        q.srwd <= sr_wdata[7];
        q.bp   <= sr_wdata[4:2];
      end
    end
  end

  assign st = q;

  // R1
  wel_set_source_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(q.wel) |-> $past(set_wel));
  // R2
  wel_clear_source_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(q.wel) |-> $past(clr_wel || done));
  // R7
  wip_set_source_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(q.wip) |-> $past(start));
  // R8
  sr_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    !load_sr |=> $stable({q.srwd, q.bp}));
endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
  import wp_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int CNT_W     = 16,
  parameter int SECT_LSB  = 16,
  parameter int SECT_BITS = 7
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [CNT_W-1:0]  cmd_bits,
  input  logic [7:0]        cmd_wdata,
  input  logic              wp_n,
  input  logic              eng_done,
  output logic              eng_start,
  output logic [7:0]        eng_op,
  output logic              res_valid,
  output logic              res_accept,
  output logic [7:0]        res_status
);
  localparam int BP_W = 3;

  stat_t                st;
  logic [SECT_BITS-1:0] sector;
  logic                 prot_hit, bp_clear;
  logic                 acc, set_wel, clr_wel, load_sr, start;

  assign sector = cmd_addr[SECT_LSB +: SECT_BITS];

  wp_region_decode #(.SECT_BITS(SECT_BITS), .BP_W(BP_W)) u_region (
    .clk(clk), .por_n(por_n), .bp(st.bp), .sector(sector),
    .hit(prot_hit), .all_clear(bp_clear));

  wp_cmd_check u_check (
    .valid(cmd_valid), .op(cmd_op), .bits_lo(cmd_bits[2:0]), .st(st),
    .wp_n(wp_n), .prot_hit(prot_hit), .bp_clear(bp_clear),
    .accept(acc), .set_wel(set_wel), .clr_wel(clr_wel),
    .load_sr(load_sr), .start(start));

  wp_status_regs u_regs (
    .clk(clk), .por_n(por_n), .set_wel(set_wel), .clr_wel(clr_wel),
    .load_sr(load_sr), .sr_wdata(cmd_wdata), .start(start),
    .done(eng_done), .st(st));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_status <= '0;
      eng_start  <= 1'b0;
      eng_op     <= '0;
    end else begin
      res_valid  <= cmd_valid;
      res_accept <= acc;
      res_status <= st;
      eng_start  <= start;
      if (start) eng_op <= cmd_op;
    end
  end

  // R9
  result_latency_chk: assert property (@(posedge clk) disable iff (!por_n)
    cmd_valid |=> res_valid);
  // R7
  busy_reject_chk: assert property (@(posedge clk) disable iff (!por_n)
    (cmd_valid && st.wip && cmd_op != OP_RDSR) |=> !res_accept);
  // R5
  bulk_needs_open_chk: assert property (@(posedge clk) disable iff (!por_n)
    (cmd_valid && cmd_op == OP_BE && st.bp != 3'd0) |=> !res_accept);
  // R3
  whole_bytes_chk: assert property (@(posedge clk) disable iff (!por_n)
    (cmd_valid && is_modify(cmd_op) && cmd_bits[2:0] != 3'd0) |=> !res_accept);
  // R1
  needs_latch_chk: assert property (@(posedge clk) disable iff (!por_n)
    (cmd_valid && is_modify(cmd_op) && !st.wel) |=> !res_accept);
  // R7
  start_with_accept_chk: assert property (@(posedge clk) disable iff (!por_n)
    eng_start |-> (res_valid && res_accept));
endmodule

// File: tb/flash_wp_ctrl_tb_top.sv
module flash_wp_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_op = '0;
  logic [23:0] cmd_addr = '0;
  logic [15:0] cmd_bits = '0;
  logic [7:0]  cmd_wdata = '0;
  logic        wp_n = 1'b1;
  logic        eng_done = 1'b0;
  logic        eng_start;
  logic [7:0]  eng_op;
  logic        res_valid, res_accept;
  logic [7:0]  res_status;

  always #2 clk = ~clk;

  flash_wp_ctrl dut_i (
    .clk(clk), .por_n(por_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_bits(cmd_bits), .cmd_wdata(cmd_wdata),
    .wp_n(wp_n), .eng_done(eng_done), .eng_start(eng_start), .eng_op(eng_op),
    .res_valid(res_valid), .res_accept(res_accept), .res_status(res_status));

  typedef struct {
    logic       acc;
    logic [7:0] stat;
    logic       start;
    logic [7:0] op;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   ended  = 0;

  // reference state kept from the requirements
  logic       m_srwd = 0, m_wel = 0, m_wip = 0;
  logic [2:0] m_bp = 0;

  function automatic int first_prot(input logic [2:0] bp);
    case (bp)
      3'd0: return 128; 3'd1: return 126; 3'd2: return 124; 3'd3: return 120;
      3'd4: return 112; 3'd5: return 96;  3'd6: return 64;  default: return 0;
    endcase
  endfunction

  function automatic logic modifies(input logic [7:0] op);
    return op == 8'h02 || op == 8'hD8 || op == 8'hC7 || op == 8'h01;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] op, input logic [23:0] addr,
                       input int bits, input logic [7:0] wd, input string tag);
    exp_t e;
    logic ok;
    int   sect;
    sect = int'(addr[22:16]);
    e.stat = {m_srwd, 2'b00, m_bp, m_wel, m_wip};
    ok = 0;
    if (m_wip) ok = (op == 8'h05);
    else if (op == 8'h05 || op == 8'h06 || op == 8'h04) ok = 1;
    else if (modifies(op) && m_wel && (bits % 8 == 0)) begin
      if (op == 8'h02 || op == 8'hD8) ok = sect < first_prot(m_bp);
      else if (op == 8'hC7)           ok = (m_bp == 0);
      else                            ok = !(m_srwd && !wp_n);
    end
    e.acc = ok; e.start = ok && modifies(op); e.op = op; e.tag = tag;
    if (ok) begin
      if (op == 8'h06) m_wel = 1;
      if (op == 8'h04) m_wel = 0;
      if (op == 8'h01) begin m_srwd = wd[7]; m_bp = wd[4:2]; end
      if (modifies(op)) m_wip = 1;
    end
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = addr; cmd_bits = 16'(bits); cmd_wdata = wd;
    exp_q.push_back(e);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic finish_op();
    @(negedge clk);
    eng_done = 1;
    if (m_wip) begin m_wip = 0; m_wel = 0; end
    @(negedge clk);
    eng_done = 0;
  endtask

  task automatic set_bp(input logic [2:0] bp, input logic srwd);
    issue(8'h06, 0, 8, 0, "R1");
    issue(8'h01, 0, 16, {srwd, 2'b00, bp, 2'b00}, "R6");
    finish_op();
  endtask

  // monitor: compare each result one falling edge after its strobe
  always @(negedge clk) begin
    if (por_n && res_valid) begin
      if (exp_q.size() == 0) check(0, "R9", 1, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        check(res_accept == e.acc, {e.tag, " accept"}, res_accept, e.acc);
        check(res_status == e.stat, {e.tag, " status"}, res_status, e.stat);
        check(eng_start == e.start, {e.tag, " start"}, eng_start, e.start);
        if (e.start) check(eng_op == e.op, {e.tag, " eng_op"}, eng_op, e.op);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(res_valid == 0, "R9 reset", res_valid, 0);
    por_n = 1;
    issue(8'h05, 0, 8, 0, "R9");
    issue(8'h02, 24'h050000, 40, 0, "R1");           // no latch
    issue(8'h06, 0, 8, 0, "R1");
    issue(8'h02, 24'h050000, 35, 0, "R3");           // partial byte
    issue(8'hD8, 24'h050000, 33, 0, "R3");
    issue(8'h02, 24'h050000, 40, 0, "R3");           // whole bytes
    issue(8'h05, 0, 8, 0, "R7");
    issue(8'h06, 0, 8, 0, "R7");                     // busy
    issue(8'hD8, 24'h010000, 32, 0, "R7");
    finish_op();
    issue(8'h05, 0, 8, 0, "R2");                     // latch cleared by done
    issue(8'h3B, 0, 8, 0, "R8");                     // unknown opcode
    issue(8'h06, 0, 8, 0, "R2");
    issue(8'h04, 0, 8, 0, "R2");
    issue(8'h01, 0, 16, 8'h1C, "R8");                // rejected, field stays
    issue(8'h05, 0, 8, 0, "R8");
    // each region step: top edge rejected, sector below accepted
    for (int b = 1; b < 8; b++) begin
      set_bp(3'(b), 0);
      issue(8'h06, 0, 8, 0, "R4");
      issue(8'h02, {1'b0, 7'(first_prot(3'(b))), 16'h0}, 64, 0, "R4");
      issue(8'hC7, 0, 8, 0, "R5");
      if (b < 7) begin
        issue(8'hD8, {1'b0, 7'(first_prot(3'(b)) - 1), 16'h0}, 32, 0, "R4");
        finish_op();
      end else begin
        issue(8'h04, 0, 8, 0, "R2");
      end
    end
    set_bp(3'd1, 0);
    issue(8'h06, 0, 8, 0, "R4");
    issue(8'h02, 24'hFE0000, 40, 0, "R4");           // bit 23 ignored
    issue(8'h02, 24'h7D0000, 40, 0, "R4");
    finish_op();
    set_bp(3'd0, 0);
    issue(8'h06, 0, 8, 0, "R5");
    issue(8'hC7, 0, 8, 0, "R5");
    finish_op();
    // hardware lock
    set_bp(3'd2, 1);
    wp_n = 0;
    issue(8'h06, 0, 8, 0, "R6");
    issue(8'h01, 0, 16, 8'h00, "R6");
    issue(8'h05, 0, 8, 0, "R6");
    wp_n = 1;
    issue(8'h01, 0, 16, 8'h00, "R6");
    finish_op();
    issue(8'h05, 0, 8, 0, "R6");
    // power-on reset clears the latch
    issue(8'h06, 0, 8, 0, "R2");
    @(negedge clk);
    por_n = 0;
    m_wel = 0; m_wip = 0; m_bp = 0; m_srwd = 0;
    @(negedge clk);
    check(res_valid == 0, "R9 reset", res_valid, 0);
    por_n = 1;
    issue(8'h05, 0, 8, 0, "R2");
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R9 drained", exp_q.size(), 0);
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule